// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address-Wake Filtering

This block receives asynchronous serial frames of 7, 8 or 9 data bits. An optional parity bit may follow the data, and one stop bit ends the frame. In asynchronous mode it counts baud ticks that arrive at sixteen times the bit rate. It confirms a start bit half a bit after the falling edge and samples each later bit at its centre. In synchronous mode every rising edge of an external clock input samples exactly one bit, and the baud ticks are ignored.

Each received frame yields a data byte and, in 9-bit mode, a ninth bit. Several conditions are kept as flags: a pending byte, a sticky parity error, a framing error, attention mode and reception in progress. A framing error is a stop bit sampled low. That flag stays high until the line returns high, and no new frame starts in the meantime. Attention mode is used for multi-drop addressing. While it is on, frames whose ninth bit is 0 are dropped, and the first frame with the ninth bit set is accepted and turns attention mode off.

Software reads the flags through a status port. A read strobe on the status port clears the parity error, and a read strobe on the data port clears the pending-byte flag. The receive interrupt is the pending-byte flag gated by an enable input.

Top module: `addr_uart_rx`

## Requirements
- R1: After reset, `status`, `rxData` and `rxIrq` are all 0.
- R2: A frame is one low start bit, then the data bits LSB first, then a parity bit if `cfgParityEn`=1, then one stop bit. The number of data bits follows `cfgWordLen`: 0 gives 7, 1 gives 8, 2 gives 9, and 3 gives 8. In asynchronous mode one bit lasts 16 baud ticks. A low pulse that is gone 8 ticks after it was first seen does not start a frame.
- R3: An accepted frame loads the low 8 data bits into `rxData`, with bit 7 = 0 in 7-bit mode. The ninth data bit goes to `status[3]` in 9-bit mode; in the other modes `status[3]` is loaded with 0.
- R4: `status[0]` (byte pending) is set when a frame is accepted. A `dataRd` pulse clears it, unless a frame is accepted in the same cycle.
- R5: With parity on, even parity (`cfgParityOdd`=0) means the XOR of the data bits and the parity bit is 0; odd parity means that XOR is 1. A mismatch in an accepted frame sets `status[1]`, and the data is still loaded. `status[1]` stays set until a `statRd` pulse clears it.
- R6: A stop bit sampled low sets `status[2]`. Such a frame does not load `rxData` or change `status[0]`. The receiver then starts no frame while the line stays low, and `status[2]` clears at the first clock edge at which `rxLine` is high.
- R7: A pulse on `attnWe` writes `attnWdata` into `status[4]`. While `status[4]`=1, a frame whose ninth bit is 0 is dropped: `rxData` is not loaded and none of the flags change. A frame whose ninth bit is 1 is accepted and clears `status[4]`. A write on `attnWe` takes priority over that clear.
- R8: With `cfgSync`=1, each rising edge of `extClk` samples one bit. A low line at an edge while idle is taken as the start bit, and `baudTick` has no effect.
- R9: `rxIrq` equals `status[0]` when `cfgRxIe`=1 and is 0 when `cfgRxIe`=0.
- R10: `status[5]` is 1 from the detection of a start bit until the stop bit is sampled, and 0 while idle. Bits 7 and 6 of `status` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| extClk | input | 1 | External bit clock for synchronous mode |
| rxLine | input | 1 | Serial receive line, idle high |
| cfgSync | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| cfgWordLen | input | 2 | Data bits per frame: 0 = 7, 1 = 8, 2 = 9, 3 = 8 |
| cfgParityEn | input | 1 | Enables a parity bit after the data |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgRxIe | input | 1 | Receive interrupt enable |
| attnWe | input | 1 | Write strobe for the attention flag |
| attnWdata | input | 1 | Value written to the attention flag |
| statRd | input | 1 | Status read strobe; clears the parity error |
| dataRd | input | 1 | Data read strobe; clears the byte-pending flag |
| rxData | output | 8 | Last accepted data byte |
| status | output | 8 | Bit 0 pending, 1 parity error, 2 framing error, 3 ninth bit, 4 attention, 5 busy |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The assertions assume that `rxLine` and `extClk` are already synchronous to `clk`, and that the configuration inputs are changed only while the receiver is idle. The bench drives every input at the falling clock edge, changes configuration only between frames, and holds each serial bit for a whole bit time: 64 clocks in asynchronous mode, or one full `extClk` period centred on its rising edge. Under these conditions the flag assertions can rely on the completion strobe being the only event that sets a flag.

// File: rtl/addr_uart_rx_pkg.sv
package addr_uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BREAK
  } rxState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic frameStart;
    logic shiftBit;
    logic parityCap;
    logic frameDone;
  } rxStrobe_t;

  localparam int STAT_W = 8;

  function automatic logic [3:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/addr_uart_rx_ctrl.sv
module addr_uart_rx_ctrl
  import addr_uart_rx_pkg::*;
#(
  parameter int OVS_RATE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       extEdge,
  input  logic       rxLine,
  input  logic       cfgSync,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParityEn,
  output rxStrobe_t  strobes,
  output logic       busy
);

  localparam int CNT_W = $clog2(OVS_RATE);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS_RATE - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS_RATE / 2 - 1);

  rxState_t       state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]     bitIdx;
  logic [3:0]     lastIdx;
  logic           sampleNow;

  always_comb lastIdx = wordBits(cfgWordLen) - 4'd1;

  // one bit sample: external edge, or the tick that reaches the sample point
  always_comb begin
    if (cfgSync) sampleNow = extEdge;
    else         sampleNow = baudTick && (tickCnt == ((state == ST_START) ? MID_TICK : LAST_TICK));
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (!rxLine && (cfgSync ? extEdge : baudTick)) begin
          stateNext          = cfgSync ? ST_DATA : ST_START;
          strobes.frameStart = 1'b1;
        end
      end
      ST_START: begin
        if (sampleNow) stateNext = rxLine ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (sampleNow) begin
          strobes.shiftBit = 1'b1;
          if (bitIdx == lastIdx) stateNext = cfgParityEn ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (sampleNow) begin
          strobes.parityCap = 1'b1;
          stateNext         = ST_STOP;
        end
      end
      ST_STOP: begin
        if (sampleNow) begin
          strobes.frameDone = 1'b1;
          stateNext         = rxLine ? ST_IDLE : ST_BREAK;
        end
      end
      ST_BREAK: begin
        if (rxLine) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state <= stateNext;
      if (strobes.frameStart || sampleNow) tickCnt <= '0;
      else if (baudTick)                   tickCnt <= tickCnt + 1'b1;
      if (strobes.frameStart)    bitIdx <= '0;
      else if (strobes.shiftBit) bitIdx <= bitIdx + 4'd1;
    end
  end

  always_comb busy = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PAR)   || (state == ST_STOP);

endmodule

// File: rtl/addr_uart_rx_dp.sv
module addr_uart_rx_dp
  import addr_uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobes,
  input  logic              busy,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              attnWe,
  input  logic              attnWdata,
  input  logic              statRd,
  input  logic              dataRd,
  output logic [7:0]        rxData,
  output logic [STAT_W-1:0] status
);

  logic [8:0] shiftReg;
  logic       parAcc, parBit;
  logic       bufFull, parErr, frameErr, ninthBit, attnMode;
  logic [7:0] frameData;
  logic       frameNinth, accept, parMismatch;

  // bits enter at the top, so the frame sits left-aligned after the last shift
  always_comb begin
    case (cfgWordLen)
      2'd0: begin frameData = {1'b0, shiftReg[8:2]}; frameNinth = 1'b0;        end
      2'd2: begin frameData = shiftReg[7:0];         frameNinth = shiftReg[8]; end
      default: begin frameData = shiftReg[8:1];      frameNinth = 1'b0;        end
    endcase
  end

  always_comb begin
    accept      = strobes.frameDone && rxLine && !(attnMode && !frameNinth);
    parMismatch = cfgParityEn && ((parAcc ^ parBit) != cfgParityOdd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      rxData   <= '0;
      ninthBit <= 1'b0;
      bufFull  <= 1'b0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
      attnMode <= 1'b0;
    end else begin
      if (strobes.frameStart) begin
        shiftReg <= '0;
        parAcc   <= 1'b0;
      end else if (strobes.shiftBit) begin
        shiftReg <= {rxLine, shiftReg[8:1]};
        parAcc   <= parAcc ^ rxLine;
      end
      if (strobes.parityCap) parBit <= rxLine;

      if (accept) begin
        rxData   <= frameData;
        ninthBit <= frameNinth;
      end

      if (accept)      bufFull <= 1'b1;
      else if (dataRd) bufFull <= 1'b0;

      if (accept && parMismatch) parErr <= 1'b1;
      else if (statRd)           parErr <= 1'b0;

      if (strobes.frameDone && !rxLine) frameErr <= 1'b1;
      else if (rxLine)                  frameErr <= 1'b0;

      if (attnWe)                    attnMode <= attnWdata;
      else if (accept && frameNinth) attnMode <= 1'b0;
    end
  end

  always_comb status = {2'b00, busy, attnMode, ninthBit, frameErr, parErr, bufFull};

endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import addr_uart_rx_pkg::*;
#(
  parameter int OVS_RATE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              extClk,
  input  logic              rxLine,
  input  logic              cfgSync,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgRxIe,
  input  logic              attnWe,
  input  logic              attnWdata,
  input  logic              statRd,
  input  logic              dataRd,
  output logic [7:0]        rxData,
  output logic [STAT_W-1:0] status,
  output logic              rxIrq
);

  rxStrobe_t strobes;
  logic      busy;
  logic      extPrev, extEdge;

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extClk;
  end

  always_comb extEdge = extClk && !extPrev;

  addr_uart_rx_ctrl #(.OVS_RATE(OVS_RATE)) ctrlInst (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .extEdge(extEdge),
    .rxLine(rxLine), .cfgSync(cfgSync), .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn), .strobes(strobes), .busy(busy)
  );

  addr_uart_rx_dp dpInst (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobes(strobes), .busy(busy),
    .cfgWordLen(cfgWordLen), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .attnWe(attnWe), .attnWdata(attnWdata), .statRd(statRd), .dataRd(dataRd),
    .rxData(rxData), .status(status)
  );

  always_comb rxIrq = status[0] && cfgRxIe;

endmodule

// File: rtl/addr_uart_rx_chk.sv
module addr_uart_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxLine,
  input logic       attnWe,
  input logic       statRd,
  input logic       dataRd,
  input logic       cfgRxIe,
  input logic       rxIrq,
  input logic [7:0] status,
  input logic       frameDone
);

  assert_ferr_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    status[2] && rxLine |=> !status[2]);

  assert_ferr_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> $past(frameDone) && !$past(rxLine));

  assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !frameDone |=> !status[0]);

  assert_full_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(frameDone));

  assert_perr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    statRd && !frameDone |=> !status[1]);

  assert_perr_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> $past(frameDone));

  assert_attn_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    status[4] && !attnWe && !frameDone |=> status[4]);

  assert_attn_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[4]) && !$past(attnWe) |-> status[3]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRxIe |-> !rxIrq);

  assert_spare_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    status[7:6] == 2'b00);

endmodule

bind addr_uart_rx addr_uart_rx_chk chkInst (
  .clk(clk), .rstN(rstN), .rxLine(rxLine), .attnWe(attnWe), .statRd(statRd),
  .dataRd(dataRd), .cfgRxIe(cfgRxIe), .rxIrq(rxIrq), .status(status),
  .frameDone(strobes.frameDone)
);

// File: tb/addr_uart_rx_test.sv
module addr_uart_rx_test;

  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       extClk = 1'b0;
  logic       rxLine = 1'b1;
  logic       cfgSync = 1'b0;
  logic [1:0] cfgWordLen = 2'd1;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgRxIe = 1'b1;
  logic       attnWe = 1'b0;
  logic       attnWdata = 1'b0;
  logic       statRd = 1'b0;
  logic       dataRd = 1'b0;
  logic [7:0] rxData;
  logic [7:0] status;
  logic       rxIrq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [9:0] expQ[$];  // {pe, ninth, data}

  addr_uart_rx uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .extClk(extClk), .rxLine(rxLine),
    .cfgSync(cfgSync), .cfgWordLen(cfgWordLen), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgRxIe(cfgRxIe), .attnWe(attnWe), .attnWdata(attnWdata),
    .statRd(statRd), .dataRd(dataRd), .rxData(rxData), .status(status), .rxIrq(rxIrq)
  );

  always #4 clk = ~clk;

  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv  <= (tickDiv == 3) ? 0 : tickDiv + 1;
    baudTick <= (tickDiv == 3);
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic waitBits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  // expected item, pushed before the frame is sent
  task automatic pushExp(input logic [8:0] d, input int nb, input bit pe);
    logic [7:0] data = (nb == 7) ? {1'b0, d[6:0]} : d[7:0];
    logic       ninth = (nb == 9) ? d[8] : 1'b0;
    expQ.push_back({pe, ninth, data});
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nb, input bit parEn,
                           input bit parOdd, input bit badPar, input bit stopVal);
    logic p = parOdd ^ badPar;
    rxLine = 1'b0;
    waitBits(1);
    for (int i = 0; i < nb; i++) begin
      rxLine = d[i];
      p ^= d[i];
      if (i == 0) begin
        repeat (BIT_CLKS / 2) @(negedge clk);
        check(status[5] == 1'b1, "R10 busy during frame", status[5], 1);
        repeat (BIT_CLKS / 2) @(negedge clk);
      end else waitBits(1);
    end
    if (parEn) begin
      rxLine = p;
      waitBits(1);
    end
    rxLine = stopVal;
    waitBits(1);
    if (stopVal) begin
      waitBits(1);
      check(status[5] == 1'b0, "R10 idle after frame", status[5], 0);
    end
  endtask

  task automatic syncBit(input logic b);
    rxLine = b;
    repeat (8) @(negedge clk);
    extClk = 1'b1;
    repeat (8) @(negedge clk);
    extClk = 1'b0;
  endtask

  // monitor: pops expected items as frames arrive, then reads both ports
  initial begin
    logic [9:0] item;
    forever begin
      @(negedge clk);
      if (rstN && status[0] && !dataRd) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected accepted frame", rxData, 0);
        end else begin
          item = expQ.pop_front();
          check(rxData == item[7:0], "R3 data byte", rxData, item[7:0]);
          check(status[3] == item[8], "R3 ninth bit", status[3], item[8]);
          check(status[1] == item[9], "R5 parity error flag", status[1], item[9]);
          check(rxIrq == cfgRxIe, "R9 interrupt gating", rxIrq, cfgRxIe);
        end
        statRd = 1'b1;
        dataRd = 1'b1;
        @(negedge clk);
        statRd = 1'b0;
        dataRd = 1'b0;
        check(status[0] == 1'b0, "R4 pending cleared by data read", status[0], 0);
        check(status[1] == 1'b0, "R5 parity error cleared by status read", status[1], 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    check(status == 8'h00, "R1 status after reset", status, 0);
    check(rxData == 8'h00, "R1 data after reset", rxData, 0);
    check(rxIrq == 1'b0, "R1 interrupt after reset", rxIrq, 0);
    rstN = 1'b1;
    waitBits(1);

    // R2/R3: 8-bit frames, interrupt enabled
    cfgWordLen = 2'd1; cfgRxIe = 1'b1;
    pushExp(9'h0A5, 8, 0); sendFrame(9'h0A5, 8, 0, 0, 0, 1);
    pushExp(9'h03C, 8, 0); sendFrame(9'h03C, 8, 0, 0, 0, 1);

    // R2/R3: 7-bit frame, top bit must read as 0
    cfgWordLen = 2'd0;
    pushExp(9'h0FF, 7, 0); sendFrame(9'h0FF, 7, 0, 0, 0, 1);

    // R3/R9: 9-bit frames with interrupt disabled
    cfgWordLen = 2'd2; cfgRxIe = 1'b0;
    pushExp(9'h1C3, 9, 0); sendFrame(9'h1C3, 9, 0, 0, 0, 1);
    pushExp(9'h05A, 9, 0); sendFrame(9'h05A, 9, 0, 0, 0, 1);
    cfgRxIe = 1'b1;

    // R5: even and odd parity, good and bad
    cfgWordLen = 2'd1; cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    pushExp(9'h081, 8, 0); sendFrame(9'h081, 8, 1, 0, 0, 1);
    pushExp(9'h081, 8, 1); sendFrame(9'h081, 8, 1, 0, 1, 1);
    cfgParityOdd = 1'b1;
    pushExp(9'h07E, 8, 0); sendFrame(9'h07E, 8, 1, 1, 0, 1);
    pushExp(9'h013, 8, 1); sendFrame(9'h013, 8, 1, 1, 1, 1);
    cfgParityEn = 1'b0; cfgParityOdd = 1'b0;

    // R2: short low glitch must not start a frame
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    waitBits(2);
    check(status[5] == 1'b0, "R2 glitch rejected (busy)", status[5], 0);
    check(status[0] == 1'b0, "R2 glitch rejected (pending)", status[0], 0);

    // R7: attention mode
    cfgWordLen = 2'd2;
    @(negedge clk); attnWe = 1'b1; attnWdata = 1'b1;
    @(negedge clk); attnWe = 1'b0;
    check(status[4] == 1'b1, "R7 attention written", status[4], 1);
    sendFrame(9'h055, 9, 0, 0, 0, 1);
    check(status[0] == 1'b0, "R7 data frame dropped", status[0], 0);
    check(status[4] == 1'b1, "R7 attention kept", status[4], 1);
    check(rxData == 8'h13, "R7 data register untouched", rxData, 8'h13);
    pushExp(9'h1A3, 9, 0); sendFrame(9'h1A3, 9, 0, 0, 0, 1);
    check(status[4] == 1'b0, "R7 attention cleared by address frame", status[4], 0);

    // R6: framing error and break
    cfgWordLen = 2'd1;
    sendFrame(9'h033, 8, 0, 0, 0, 0);
    waitBits(3);
    check(status[2] == 1'b1, "R6 framing error set", status[2], 1);
    check(status[5] == 1'b0, "R6 no frame while line low", status[5], 0);
    check(status[0] == 1'b0, "R6 no data from bad frame", status[0], 0);
    check(rxData == 8'hA3, "R6 data register untouched", rxData, 8'hA3);
    rxLine = 1'b1;
    @(negedge clk);
    check(status[2] == 1'b0, "R6 framing error cleared on line high", status[2], 0);
    waitBits(1);

    // R8: synchronous mode
    cfgSync = 1'b1;
    pushExp(9'h096, 8, 0);
    syncBit(1'b0);
    for (int i = 0; i < 8; i++) syncBit(8'h96 >> i);
    syncBit(1'b1);
    syncBit(1'b1);
    repeat (8) @(negedge clk);
    check(status[5] == 1'b0, "R8 sync frame complete", status[5], 0);
    waitBits(2);
    check(status[0] == 1'b0, "R8 baud ticks ignored in sync idle", status[0], 0);
    cfgSync = 1'b0;

    waitBits(1);
    check(expQ.size() == 0, "R4 all expected frames received", expQ.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule